// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table from memory. A caller pulses a start strobe and supplies the virtual address, the table base and a flag that enables tiny-page tables. The walker then issues one or two single-word reads over a simple request/response port and reports the outcome.

On success the walker returns the physical address, a page-kind code, the cacheable/bufferable pair, the 4-bit domain and the permission field. If a translation fault is hit instead, it raises a fault flag and clears every result field. It does not check permissions, enforce domains, cache translations or touch caches. It sits beside a debug or refill agent that needs the mapping of one address at a time.

Top module: `ptw_walker`

## Requirements
- R1: The first read address is table-base bits [31:14], then virtual bits [31:20], then two zero bits.
- R2: A first-level word with bits [1:0] = 2 is a section. The walk completes after one read with physical address {word[31:20], va[19:0]}, kind code 0, cb = word[3:2], permission = word[11:10] zero-extended to 8 bits, and domain = word[8:5].
- R3: A first-level word with bits [1:0] = 1 selects a coarse table. The second read address is {word[31:10], va[19:12], 2'b00}.
- R4: A first-level word with bits [1:0] = 3 and tiny pages enabled selects a fine table. The second read address is {word[31:12], va[19:10], 2'b00}.
- R5: A first-level word with bits [1:0] = 3 and tiny pages disabled ends the walk as a fault after one read.
- R6: A second-level word with bits [1:0] = 1 is a large page: physical address {word[31:16], va[15:0]}, kind code 1, permission = word[11:4].
- R7: A second-level word with bits [1:0] = 2 is a small page: physical address {word[31:12], va[11:0]}, kind code 2, permission = word[11:4].
- R8: A second-level word with bits [1:0] = 3 is a tiny page: physical address {word[31:10], va[9:0]}, kind code 3, permission = word[5:4] zero-extended. For every second-level page, cb = word[3:2] and the domain comes from first-level bits [8:5].
- R9: A word with bits [1:0] = 0 at either level is a fault. The fault flag is set, and the physical address, kind, cb, domain and permission outputs are all zero.
- R10: busy is high from the cycle after an accepted start until completion. done is a one-cycle pulse in the cycle after the final read response, with busy low.
- R11: A start while busy, and a response-valid pulse while no read is outstanding, have no effect.
- R12: Result outputs hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| vaddr_i | input | 32 | Virtual address to translate |
| ttb_i | input | 32 | Translation table base |
| tiny_en_i | input | 1 | Enables fine (tiny-page) tables |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 32 | Word address of the read |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response word |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 1 | Last walk ended in a fault |
| paddr_o | output | 32 | Physical address |
| ptype_o | output | 2 | Kind: 0 section, 1 large, 2 small, 3 tiny |
| cb_o | output | 2 | Cacheable/bufferable bits |
| domain_o | output | 4 | Domain |
| ap_o | output | 8 | Permission field |

## Verification
The table in the bench is filled so that each descriptor kind is reached: a section, a coarse table leading to large, small, tiny and empty entries, and a fine table walked once with tiny pages on and once with them off. This separates the two second-level index rules, the three page address splits and the two permission widths. An empty first-level slot shows the early fault path. Response latency varies between one and three cycles, so the completion timing is checked against the final response rather than against a fixed count. Extra starts during a walk and stray response pulses while idle show that neither disturbs the walk in progress or the held result.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned DOM_W  = 4;
    localparam int unsigned CB_W   = 2;
    localparam int unsigned PERM_W = 8;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_L1   = 2'd1,
        WS_L2   = 2'd2
    } walk_state_e;

    typedef enum logic [1:0] {
        PG_SECTION = 2'd0,
        PG_LARGE   = 2'd1,
        PG_SMALL   = 2'd2,
        PG_TINY    = 2'd3
    } page_kind_e;

    localparam logic [1:0] TOP_EMPTY   = 2'd0;
    localparam logic [1:0] TOP_COARSE  = 2'd1;
    localparam logic [1:0] TOP_SECTION = 2'd2;
    localparam logic [1:0] TOP_FINE    = 2'd3;

    typedef struct packed {
        logic              fault;
        logic              leaf;
        word_t             paddr;
        page_kind_e        kind;
        logic [CB_W-1:0]   cb;
        logic [PERM_W-1:0] perm;
    } leaf_t;

    typedef struct packed {
        walk_state_e       st;
        word_t             va;
        logic              tiny;
        logic [DOM_W-1:0]  walk_dom;
        logic              req;
        word_t             addr;
        logic              done;
        logic              fault;
        word_t             paddr;
        page_kind_e        kind;
        logic [CB_W-1:0]   cb;
        logic [DOM_W-1:0]  dom;
        logic [PERM_W-1:0] perm;
    } walk_regs_t;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  word_t ttb,
    input  word_t va_new,
    input  word_t va_walk,
    input  word_t top_desc,
    output word_t l1_addr,
    output word_t l2_addr
);
    localparam int unsigned PAD = 2;

    logic unused_bits;

    always_comb begin
        l1_addr = {ttb[31:14], va_new[31:20], {PAD{1'b0}}};
        if (top_desc[1:0] == TOP_FINE) begin
            l2_addr = {top_desc[31:12], va_walk[19:10], {PAD{1'b0}}};
        end else begin
            l2_addr = {top_desc[31:10], va_walk[19:12], {PAD{1'b0}}};
        end
    end

    assign unused_bits = ^{ttb[13:0], va_new[19:0], va_walk[31:20], va_walk[9:0]};

endmodule

// File: rtl/ptw_leaf_decode.sv
module ptw_leaf_decode
    import ptw_pkg::*;
(
    input  word_t desc,
    input  word_t va,
    input  logic  second_lvl,
    input  logic  tiny_en,
    output leaf_t res
);
    localparam int unsigned NARROW_PAD = PERM_W - 2;

    logic unused_bits;

    always_comb begin
        res = '0;
        if (!second_lvl) begin
            unique case (desc[1:0])
                TOP_EMPTY: begin
                    res.fault = 1'b1;
                    res.leaf  = 1'b1;
                end
                TOP_SECTION: begin
                    res.leaf  = 1'b1;
                    res.paddr = {desc[31:20], va[19:0]};
                    res.kind  = PG_SECTION;
                    res.cb    = desc[3:2];
                    res.perm  = {{NARROW_PAD{1'b0}}, desc[11:10]};
                end
                TOP_FINE: begin
                    if (!tiny_en) begin
                        res.fault = 1'b1;
                        res.leaf  = 1'b1;
                    end
                end
                default: ;
            endcase
        end else begin
            res.leaf = 1'b1;
            res.cb   = desc[3:2];
            unique case (desc[1:0])
                2'd0: begin
                    res.fault = 1'b1;
                    res.cb    = '0;
                end
                2'd1: begin
                    res.paddr = {desc[31:16], va[15:0]};
                    res.kind  = PG_LARGE;
                    res.perm  = desc[11:4];
                end
                2'd2: begin
                    res.paddr = {desc[31:12], va[11:0]};
                    res.kind  = PG_SMALL;
                    res.perm  = desc[11:4];
                end
                default: begin
                    res.paddr = {desc[31:10], va[9:0]};
                    res.kind  = PG_TINY;
                    res.perm  = {{NARROW_PAD{1'b0}}, desc[5:4]};
                end
            endcase
        end
    end

    assign unused_bits = ^va[31:20];

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [31:0] vaddr_i,
    input  logic [31:0] ttb_i,
    input  logic        tiny_en_i,
    output logic        busy_o,
    output logic        mem_req_o,
    output logic [31:0] mem_addr_o,
    input  logic        mem_rvalid_i,
    input  logic [31:0] mem_rdata_i,
    output logic        done_o,
    output logic        fault_o,
    output logic [31:0] paddr_o,
    output logic [1:0]  ptype_o,
    output logic [1:0]  cb_o,
    output logic [3:0]  domain_o,
    output logic [7:0]  ap_o
);
    walk_regs_t r_d, r_q;
    word_t      l1_addr, l2_addr;
    leaf_t      leaf;
    logic       finish;
    logic [DOM_W-1:0] fin_dom;

    ptw_addr_gen u_addr (
        .ttb      (ttb_i),
        .va_new   (vaddr_i),
        .va_walk  (r_q.va),
        .top_desc (mem_rdata_i),
        .l1_addr  (l1_addr),
        .l2_addr  (l2_addr)
    );

    ptw_leaf_decode u_dec (
        .desc       (mem_rdata_i),
        .va         (r_q.va),
        .second_lvl (r_q.st == WS_L2),
        .tiny_en    (r_q.tiny),
        .res        (leaf)
    );

    always_comb begin
        r_d      = r_q;
        r_d.req  = 1'b0;
        r_d.done = 1'b0;
        finish   = 1'b0;
        fin_dom  = r_q.walk_dom;
        unique case (r_q.st)
            WS_IDLE: begin
                if (start_i) begin
                    r_d.st   = WS_L1;
                    r_d.va   = vaddr_i;
                    r_d.tiny = tiny_en_i;
                    r_d.req  = 1'b1;
                    r_d.addr = l1_addr;
                end
            end
            WS_L1: begin
                if (mem_rvalid_i) begin
                    if (leaf.leaf) begin
                        finish  = 1'b1;
                        fin_dom = mem_rdata_i[8:5];
                    end else begin
                        r_d.walk_dom = mem_rdata_i[8:5];
                        r_d.req      = 1'b1;
                        r_d.addr     = l2_addr;
                        r_d.st       = WS_L2;
                    end
                end
            end
            WS_L2: begin
                if (mem_rvalid_i) begin
                    finish = 1'b1;
                end
            end
            default: r_d.st = WS_IDLE;
        endcase
        if (finish) begin
            r_d.st    = WS_IDLE;
            r_d.done  = 1'b1;
            r_d.fault = leaf.fault;
            if (leaf.fault) begin
                r_d.paddr = '0;
                r_d.kind  = PG_SECTION;
                r_d.cb    = '0;
                r_d.dom   = '0;
                r_d.perm  = '0;
            end else begin
                r_d.paddr = leaf.paddr;
                r_d.kind  = leaf.kind;
                r_d.cb    = leaf.cb;
                r_d.dom   = fin_dom;
                r_d.perm  = leaf.perm;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o     = (r_q.st != WS_IDLE);
    assign mem_req_o  = r_q.req;
    assign mem_addr_o = r_q.addr;
    assign done_o     = r_q.done;
    assign fault_o    = r_q.fault;
    assign paddr_o    = r_q.paddr;
    assign ptype_o    = r_q.kind;
    assign cb_o       = r_q.cb;
    assign domain_o   = r_q.dom;
    assign ap_o       = r_q.perm;

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[1:0] == 2'b00)); // R1
    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> busy_o); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R10
    AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o) |-> (paddr_o == '0 && ap_o == '0 && domain_o == '0)); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(paddr_o) && $stable(ap_o) && $stable(fault_o))); // R12
    AST_NO_REQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_req_o); // R11

endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] vaddr_i = '0;
    logic [31:0] ttb_i = '0;
    logic        tiny_en_i = 1'b0;
    logic        busy_o, mem_req_o, done_o, fault_o;
    logic [31:0] mem_addr_o, paddr_o;
    logic        mem_rvalid_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic [1:0]  ptype_o, cb_o;
    logic [3:0]  domain_o;
    logic [7:0]  ap_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] mem [logic [31:0]];

    logic [31:0] cur_va, cur_ttb;
    logic        cur_tiny;
    logic [31:0] top_word;
    int          rd_idx = 0;
    logic        pend = 1'b0;
    int          pend_cnt = 0;
    logic [31:0] pend_data;
    int          lat_seed = 0;
    logic        exp_done = 1'b0;
    logic        inject_spur = 1'b0;
    logic        fin;

    localparam logic [31:0] TTB = 32'h0000_8000;

    always #10 clk = ~clk;

    ptw_walker uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vaddr_i(vaddr_i),
        .ttb_i(ttb_i), .tiny_en_i(tiny_en_i), .busy_o(busy_o),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
        .done_o(done_o), .fault_o(fault_o), .paddr_o(paddr_o),
        .ptype_o(ptype_o), .cb_o(cb_o), .domain_o(domain_o), .ap_o(ap_o)
    );

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Reference translation, written from the requirements.
    task automatic ref_walk(input logic [31:0] va, input logic [31:0] ttb, input logic tiny,
                            output logic [48:0] res);
        logic [31:0] d1, d2, pa;
        logic [1:0]  pt, cb;
        logic [3:0]  dm;
        logic [7:0]  ap;
        logic        f;
        f = 1'b0; pa = 0; pt = 0; cb = 0; dm = 0; ap = 0; d2 = 0;
        d1 = rd({ttb[31:14], va[31:20], 2'b00});
        if (d1[1:0] == 2'd0 || (d1[1:0] == 2'd3 && !tiny)) begin
            f = 1'b1;
        end else if (d1[1:0] == 2'd2) begin
            pa = {d1[31:20], va[19:0]}; cb = d1[3:2]; dm = d1[8:5]; ap = {6'b0, d1[11:10]};
        end else begin
            if (d1[1:0] == 2'd1) d2 = rd({d1[31:10], va[19:12], 2'b00});
            else                 d2 = rd({d1[31:12], va[19:10], 2'b00});
            dm = d1[8:5];
            cb = d2[3:2];
            case (d2[1:0])
                2'd0: f = 1'b1;
                2'd1: begin pa = {d2[31:16], va[15:0]}; pt = 2'd1; ap = d2[11:4]; end
                2'd2: begin pa = {d2[31:12], va[11:0]}; pt = 2'd2; ap = d2[11:4]; end
                default: begin pa = {d2[31:10], va[9:0]}; pt = 2'd3; ap = {6'b0, d2[5:4]}; end
            endcase
        end
        if (f) begin pa = 0; pt = 0; cb = 0; dm = 0; ap = 0; end
        res = {f, pa, pt, cb, dm, ap};
    endtask

    // Memory responder and per-clock completion model.
    always @(negedge clk) begin
        if (!rst_n) begin
            exp_done = 1'b0; pend = 1'b0; mem_rvalid_i = 1'b0; rd_idx = 0;
        end else begin
            check(done_o === exp_done, "R10 done timing", {63'b0, done_o}, {63'b0, exp_done});
            exp_done = 1'b0;
            mem_rvalid_i = 1'b0;
            if (pend) begin
                if (pend_cnt == 1) begin
                    mem_rvalid_i = 1'b1;
                    mem_rdata_i = pend_data;
                    pend = 1'b0;
                    if (rd_idx == 0) begin
                        top_word = pend_data;
                        fin = (pend_data[1:0] == 2'd0) || (pend_data[1:0] == 2'd2) ||
                              (pend_data[1:0] == 2'd3 && !cur_tiny);
                        rd_idx = fin ? 0 : 1;
                    end else begin
                        fin = 1'b1;
                        rd_idx = 0;
                    end
                    exp_done = fin;
                end else begin
                    pend_cnt--;
                end
            end else if (inject_spur) begin
                mem_rvalid_i = 1'b1;
                mem_rdata_i = 32'hDEAD_BEE2;
                inject_spur = 1'b0;
            end
            if (mem_req_o) begin
                if (rd_idx == 0)
                    check(mem_addr_o === {cur_ttb[31:14], cur_va[31:20], 2'b00}, "R1 first read address",
                          {32'b0, mem_addr_o}, {32'b0, cur_ttb[31:14], cur_va[31:20], 2'b00});
                else if (top_word[1:0] == 2'd1)
                    check(mem_addr_o === {top_word[31:10], cur_va[19:12], 2'b00}, "R3 coarse read address",
                          {32'b0, mem_addr_o}, {32'b0, top_word[31:10], cur_va[19:12], 2'b00});
                else
                    check(mem_addr_o === {top_word[31:12], cur_va[19:10], 2'b00}, "R4 fine read address",
                          {32'b0, mem_addr_o}, {32'b0, top_word[31:12], cur_va[19:10], 2'b00});
                pend = 1'b1;
                pend_cnt = 1 + (lat_seed % 3);
                lat_seed++;
                pend_data = rd(mem_addr_o);
            end
        end
    end

    task automatic walk(input logic [31:0] va, input logic tiny, input logic poke, input string tag);
        logic [48:0] expv;
        logic [48:0] got;
        int guard;
        ref_walk(va, TTB, tiny, expv);
        @(negedge clk);
        cur_va = va; cur_ttb = TTB; cur_tiny = tiny;
        vaddr_i = va; ttb_i = TTB; tiny_en_i = tiny; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R10 busy after start", {63'b0, busy_o}, 64'd1);
        if (poke) begin
            @(negedge clk);
            start_i = 1'b1; vaddr_i = 32'h4000_0000; tiny_en_i = ~tiny;
            @(negedge clk);
            start_i = 1'b0;
        end
        guard = 0;
        while (done_o !== 1'b1 && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        got = {fault_o, paddr_o, ptype_o, cb_o, domain_o, ap_o};
        check(got === expv, tag, {15'b0, got}, {15'b0, expv});
        check(busy_o === 1'b0, "R10 idle at done", {63'b0, busy_o}, 64'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [48:0] held;
        // Section, domain 5, cb 3, perm 3
        mem[{TTB[31:14], 12'h123, 2'b00}] = 32'hABC0_0CAE;
        // Coarse table at 0x10400, domain 9
        mem[{TTB[31:14], 12'h200, 2'b00}] = 32'h0001_0521;
        mem[32'h0001_04D0] = 32'h5555_0A55;
        mem[32'h0001_04D4] = 32'h7777_73CA;
        mem[32'h0001_04D8] = 32'h9999_98E3;
        // Fine table at 0x23000, domain 15
        mem[{TTB[31:14], 12'h300, 2'b00}] = 32'h0002_31E3;
        mem[32'h0002_3120] = 32'h4242_4FF6;

        repeat (3) @(negedge clk);
        check(busy_o === 1'b0 && done_o === 1'b0 && mem_req_o === 1'b0, "R10 reset idle",
              {61'b0, busy_o, done_o, mem_req_o}, 64'd0);
        check(paddr_o === 32'h0 && fault_o === 1'b0, "R12 reset result", {31'b0, fault_o, paddr_o}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        walk(32'h1234_5678, 1'b0, 1'b0, "R2 section");
        walk(32'h2003_4567, 1'b0, 1'b0, "R6 large page");
        walk(32'h2003_5ABC, 1'b1, 1'b0, "R7 small page");
        walk(32'h2003_6123, 1'b0, 1'b0, "R8 tiny page");
        walk(32'h2003_7000, 1'b0, 1'b0, "R9 second-level fault");
        walk(32'h4000_0000, 1'b1, 1'b0, "R9 first-level fault");
        walk(32'h3001_2345, 1'b1, 1'b0, "R4 fine small page");
        walk(32'h3001_2345, 1'b0, 1'b0, "R5 fine with tiny off");
        walk(32'h2003_5ABC, 1'b0, 1'b1, "R11 start while busy");
        walk(32'h3001_2345, 1'b1, 1'b1, "R11 start while busy fine");

        held = {fault_o, paddr_o, ptype_o, cb_o, domain_o, ap_o};
        repeat (6) @(negedge clk);
        check({fault_o, paddr_o, ptype_o, cb_o, domain_o, ap_o} === held, "R12 result held",
              {15'b0, fault_o, paddr_o, ptype_o, cb_o, domain_o, ap_o}, {15'b0, held});

        @(posedge clk);
        inject_spur = 1'b1;
        repeat (4) @(negedge clk);
        check(busy_o === 1'b0 && mem_req_o === 1'b0, "R11 stray response while idle",
              {62'b0, busy_o, mem_req_o}, 64'd0);
        check({fault_o, paddr_o, ptype_o, cb_o, domain_o, ap_o} === held, "R11 stray response keeps result",
              {15'b0, fault_o, paddr_o, ptype_o, cb_o, domain_o, ap_o}, {15'b0, held});

        walk(32'h1234_5678, 1'b1, 1'b0, "R2 section again");
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule